// File: doc/BRIEF.md
# Video Line-Interrupt Status Unit

This block is the CPU-facing side of a video display processor. It handles three jobs for the host. It collects control-register writes that arrive as byte pairs on one control port. It watches the timing generator's blanking signals and raises two event flags: a scanline-match flag when horizontal blank begins on a programmed line, and a frame flag when vertical blank begins. It answers status reads on the same port and drives an active-high interrupt request.

Some status bits clear when they are read. The usual way to do this has a race: if an event lands in the same cycle as the read, the read can wipe it before the CPU ever sees it. This unit takes a snapshot of the selected status byte on the read strobe. It then clears only the flag bits that the snapshot actually returned. An event that arrives during the read stays pending for the next read.

The interrupt output follows a newly set enabled flag by a fixed lag of `IRQ_LAG` cycles. When a handler reads the status, it therefore always finds the flag already set. Video generation, memory access and the timing generator itself lie outside this block.

Top module: `vlirq_unit`

## Requirements
- R1: A register write is a byte pair on the control port. The first byte is the data. The second byte has bit 7 set and carries the register number in bits 5:0; the data is written into that register when the second byte arrives. A second byte with bit 7 clear writes nothing and returns the sequencer to expecting a data byte.
- R2: A status read puts the write sequencer back to expecting a data byte, so a half-finished byte pair is dropped.
- R3: Bits 1:0 of register 15 select which status byte a read returns: 0, 1 or 2. Selector 3 returns 0x00 and clears nothing. The snapshot appears on `cpu_rdata` in the cycle after the read strobe and holds until the next read. After reset the selector is 0.
- R4: The scanline-match flag is bit 0 of status 1. It sets on the first cycle of `hblank` high when `scan_line` equals register 19. It does not set when the two differ.
- R5: The frame flag is bit 7 of status 0. It sets on the first cycle of `vblank` high.
- R6: A read clears a flag only when that flag was returned as 1 in the snapshot. A flag that sets in the same cycle as the read is returned as 0 and stays set for the next read.
- R7: Status 2 returns the live levels of `vblank` in bit 6 and of `hblank` in bit 5. Reading it clears nothing.
- R8: `irq_req` is the OR of two terms: the scanline-match flag when register 0 bit 4 is set, and the frame flag when register 1 bit 5 is set. It rises `IRQ_LAG` (default 2) cycles after an enabled flag sets. It falls in the cycle the last enabled pending flag clears.
- R9: Reset clears every register and flag, selects status 0, sets `cpu_rdata` to 0x00 and holds `irq_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_line | input | LINE_W | Current scanline number from the timing generator |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| cpu_wr | input | 1 | Control-port write strobe, one cycle per byte |
| cpu_wdata | input | 8 | Control-port write byte |
| cpu_rd | input | 1 | Control-port read strobe, one cycle per read |
| cpu_rdata | output | 8 | Status snapshot from the latest read |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
The bench aims squarely at the collision between a read and a flag being set in the same cycle. A design that clears the flag unconditionally loses the event, and the follow-up read then comes back 0 instead of 1. It also counts the interrupt lag cycle by cycle. An output that follows the flag at once, or one cycle late, is caught by the sample taken one cycle after the flag sets. Further directed cases check that a read dropped into the middle of a byte pair discards that pair, that a second byte without bit 7 writes nothing, and that the live blanking bits survive repeated reads; each of these mistakes would change the flag or byte that a later read returns.

// File: rtl/vlirq_pkg.sv
package vlirq_pkg;

   typedef logic [7:0] byte_t;

   typedef enum logic {
      SEQ_DATA = 1'b0,
      SEQ_CMD  = 1'b1
   } seq_e;

   typedef struct packed {
      byte_t mode0;
      byte_t mode1;
      byte_t stsel;
      byte_t line;
   } ctl_regs_t;

   localparam int NUM_FLAGS = 2;
   localparam int FLG_LINE  = 0;
   localparam int FLG_FRAME = 1;

endpackage

// File: rtl/vlirq_portseq.sv
module vlirq_portseq
   import vlirq_pkg::*;
#(
   parameter int REG_MODE0 = 0,
   parameter int REG_MODE1 = 1,
   parameter int REG_STSEL = 15,
   parameter int REG_LINE  = 19
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr,
   input  byte_t     wdata,
   input  logic      rd,
   output ctl_regs_t regs
);

   localparam int RNUM_W = 6;

   seq_e      state;
   byte_t     hold;
   ctl_regs_t regs_q;

   logic [RNUM_W-1:0] rnum;
   logic              commit;

   assign rnum   = wdata[RNUM_W-1:0];
   assign commit = wr && !rd && (state == SEQ_CMD) && wdata[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_DATA;
         hold  <= '0;
      end else if (rd) begin
         state <= SEQ_DATA;
      end else if (wr) begin
         if (state == SEQ_DATA) begin
            hold  <= wdata;
            state <= SEQ_CMD;
         end else begin
            state <= SEQ_DATA;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (commit) begin
         if (rnum == RNUM_W'(REG_MODE0)) regs_q.mode0 <= hold;
         if (rnum == RNUM_W'(REG_MODE1)) regs_q.mode1 <= hold;
         if (rnum == RNUM_W'(REG_STSEL)) regs_q.stsel <= hold;
         if (rnum == RNUM_W'(REG_LINE))  regs_q.line  <= hold;
      end
   end

   assign regs = regs_q;

endmodule

// File: rtl/vlirq_flags.sv
module vlirq_flags
   import vlirq_pkg::*;
#(
   parameter int LINE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hblank,
   input  logic                 vblank,
   input  logic [LINE_W-1:0]    scan_line,
   input  logic [LINE_W-1:0]    line_cmp,
   input  logic [NUM_FLAGS-1:0] clr,
   output logic [NUM_FLAGS-1:0] flags
);

   logic hb_q, vb_q;
   logic [NUM_FLAGS-1:0] set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hb_q <= 1'b0;
         vb_q <= 1'b0;
      end else begin
         hb_q <= hblank;
         vb_q <= vblank;
      end
   end

   assign set[FLG_LINE]  = hblank && !hb_q && (scan_line == line_cmp);
   assign set[FLG_FRAME] = vblank && !vb_q;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= (f_q && !clr[g]) || set[g];
      end
      assign flags[g] = f_q;
   end

endmodule

// File: rtl/vlirq_irqdly.sv
module vlirq_irqdly #(
   parameter int LAG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   output logic irq
);

   if (LAG == 0) begin : g_direct
      assign irq = src;
   end else if (LAG == 1) begin : g_one
      logic stage;
      always_ff @(posedge clk) begin
         if (!rst_n) stage <= 1'b0;
         else        stage <= src;
      end
      assign irq = stage && src;
   end else begin : g_chain
      logic [LAG-1:0] pipe;
      always_ff @(posedge clk) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[LAG-2:0], src};
      end
      assign irq = pipe[LAG-1] && src;
   end

endmodule

// File: rtl/vlirq_unit.sv
module vlirq_unit
   import vlirq_pkg::*;
#(
   parameter int LINE_W      = 8,
   parameter int IRQ_LAG     = 2,
   parameter int REG_MODE0   = 0,
   parameter int REG_MODE1   = 1,
   parameter int REG_STSEL   = 15,
   parameter int REG_LINE    = 19,
   parameter int LINE_IE_BIT = 4,
   parameter int VB_IE_BIT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] scan_line,
   input  logic              hblank,
   input  logic              vblank,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_rd,
   output logic [7:0]        cpu_rdata,
   output logic              irq_req
);

   if (LINE_W < 1 || LINE_W > 8)
      $error("vlirq_unit: LINE_W must be 1..8");
   if (IRQ_LAG < 0 || IRQ_LAG > 16)
      $error("vlirq_unit: IRQ_LAG must be 0..16");
   if (REG_MODE0 > 63 || REG_MODE1 > 63 || REG_STSEL > 63 || REG_LINE > 63)
      $error("vlirq_unit: register numbers must fit six bits");
   if (LINE_IE_BIT > 7 || VB_IE_BIT > 7)
      $error("vlirq_unit: enable bit positions must be 0..7");

   ctl_regs_t            regs;
   logic [NUM_FLAGS-1:0] flags, clr;
   logic [LINE_W-1:0]    line_cmp;
   logic [1:0]           sel;
   byte_t                status, rd_hold;
   logic                 line_flag, vb_flag, line_ie, vb_ie, irq_src;

   vlirq_portseq #(
      .REG_MODE0(REG_MODE0), .REG_MODE1(REG_MODE1),
      .REG_STSEL(REG_STSEL), .REG_LINE(REG_LINE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata),
      .rd(cpu_rd), .regs(regs)
   );

   assign line_cmp = regs.line[LINE_W-1:0];
   assign sel      = regs.stsel[1:0];
   assign line_ie  = regs.mode0[LINE_IE_BIT];
   assign vb_ie    = regs.mode1[VB_IE_BIT];

   vlirq_flags #(.LINE_W(LINE_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
      .scan_line(scan_line), .line_cmp(line_cmp), .clr(clr), .flags(flags)
   );

   assign line_flag = flags[FLG_LINE];
   assign vb_flag   = flags[FLG_FRAME];

   always_comb begin
      status = '0;
      case (sel)
         2'd0:    status[7] = vb_flag;
         2'd1:    status[0] = line_flag;
         2'd2:    begin
                     status[6] = vblank;
                     status[5] = hblank;
                  end
         default: status = '0;
      endcase
   end

   assign clr[FLG_LINE]  = cpu_rd && (sel == 2'd1) && status[0];
   assign clr[FLG_FRAME] = cpu_rd && (sel == 2'd0) && status[7];

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_hold <= '0;
      else if (cpu_rd) rd_hold <= status;
   end

   assign cpu_rdata = rd_hold;
   assign irq_src   = (line_flag && line_ie) || (vb_flag && vb_ie);

   vlirq_irqdly #(.LAG(IRQ_LAG)) u_irq (
      .clk(clk), .rst_n(rst_n), .src(irq_src), .irq(irq_req)
   );

   logic ctl_unused;
   assign ctl_unused = ^{regs.stsel[7:2], regs.line, regs.mode0, regs.mode1};

endmodule

// File: rtl/vlirq_unit_chk.sv
module vlirq_unit_chk #(
   parameter int LINE_W = 8,
   parameter int LAG    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hblank,
   input logic              cpu_rd,
   input logic [LINE_W-1:0] scan_line,
   input logic [LINE_W-1:0] line_cmp,
   input logic              line_flag,
   input logic              vb_flag,
   input logic              line_ie,
   input logic              vb_ie,
   input logic              irq_src,
   input logic              irq_req,
   input logic [7:0]        cpu_rdata
);

   p_line_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hblank) && scan_line == line_cmp) |=> line_flag);

   p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_flag && !cpu_rd) |=> line_flag);

   p_frame_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vb_flag && !cpu_rd) |=> vb_flag);

   p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));

   p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((line_flag && line_ie) || (vb_flag && vb_ie)));

   if (LAG >= 1) begin : g_lag
      p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_req) |-> (irq_src && $past(irq_src)));
   end

endmodule

bind vlirq_unit vlirq_unit_chk #(.LINE_W(LINE_W), .LAG(IRQ_LAG)) u_chk (
   .clk(clk), .rst_n(rst_n), .hblank(hblank), .cpu_rd(cpu_rd),
   .scan_line(scan_line), .line_cmp(line_cmp), .line_flag(line_flag),
   .vb_flag(vb_flag), .line_ie(line_ie), .vb_ie(vb_ie), .irq_src(irq_src),
   .irq_req(irq_req), .cpu_rdata(cpu_rdata)
);

// File: tb/vlirq_unit_test.sv
module vlirq_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {line register, scanline at hblank, expected status 1 byte}
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd150, 8'd150, 8'h01},
      {8'd150, 8'd149, 8'h00},
      {8'd0,   8'd0,   8'h01},
      {8'd255, 8'd255, 8'h01},
      {8'd10,  8'd11,  8'h00},
      {8'd77,  8'd77,  8'h01}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] scan_line = '0;
   logic       hblank = 1'b0, vblank = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       irq_req;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   vlirq_unit uut (
      .clk(clk), .rst_n(rst_n), .scan_line(scan_line), .hblank(hblank),
      .vblank(vblank), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .irq_req(irq_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] b);
      cpu_wr = 1'b1; cpu_wdata = b;
      cyc();
      cpu_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [5:0] n, input logic [7:0] v);
      wr_byte(v);
      wr_byte({2'b10, n});
   endtask

   task automatic rd(output logic [7:0] v);
      cpu_rd = 1'b1;
      cyc();
      cpu_rd = 1'b0;
      v = cpu_rdata;
   endtask

   task automatic hpulse(input logic [7:0] ln);
      scan_line = ln; hblank = 1'b1;
      cyc();
      hblank = 1'b0;
      cyc();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) cyc();
      // R9: reset state
      chk("R9 irq after reset", {7'b0, irq_req}, 8'h00);
      chk("R9 rdata after reset", cpu_rdata, 8'h00);
      rst_n = 1'b1;
      cyc();
      rd(v); chk("R9 default status 0", v, 8'h00);

      // R4 table: line compare under several patterns, then R6 clear
      wr_reg(6'd15, 8'h01);
      for (int i = 0; i < NVEC; i++) begin
         wr_reg(6'd19, VEC[i][23:16]);
         hpulse(VEC[i][15:8]);
         rd(v); chk("R4 line match", v, VEC[i][7:0]);
         rd(v); chk("R6 cleared after read", v, 8'h00);
      end

      // R8: interrupt lag and release
      wr_reg(6'd0, 8'h10);
      wr_reg(6'd19, 8'd40);
      scan_line = 8'd40; hblank = 1'b1;
      cyc();
      hblank = 1'b0;
      chk("R8 irq at flag set", {7'b0, irq_req}, 8'h00);
      cyc();
      chk("R8 irq one cycle later", {7'b0, irq_req}, 8'h00);
      cyc();
      chk("R8 irq after lag", {7'b0, irq_req}, 8'h01);
      rd(v);
      chk("R8 flag seen by handler", v, 8'h01);
      chk("R8 irq falls on clear", {7'b0, irq_req}, 8'h00);

      // R8: disabled line enable leaves irq low
      wr_reg(6'd0, 8'h00);
      hpulse(8'd40);
      repeat (3) cyc();
      chk("R8 irq masked", {7'b0, irq_req}, 8'h00);
      rd(v); chk("R4 flag set while masked", v, 8'h01);

      // R5/R8: frame flag through its own enable
      wr_reg(6'd1, 8'h20);
      wr_reg(6'd15, 8'h00);
      vblank = 1'b1;
      repeat (3) cyc();
      chk("R8 frame irq", {7'b0, irq_req}, 8'h01);
      vblank = 1'b0;
      rd(v); chk("R5 frame flag", v, 8'h80);
      chk("R8 frame irq released", {7'b0, irq_req}, 8'h00);
      rd(v); chk("R5 frame flag cleared", v, 8'h00);
      wr_reg(6'd1, 8'h00);

      // R7: live blanking bits survive reads
      wr_reg(6'd15, 8'h02);
      scan_line = 8'd200;
      hblank = 1'b1; vblank = 1'b1;
      cyc();
      rd(v); chk("R7 live bits", v, 8'h60);
      rd(v); chk("R7 live bits not cleared", v, 8'h60);
      hblank = 1'b0; vblank = 1'b0;
      cyc();
      rd(v); chk("R7 live bits low", v, 8'h00);
      wr_reg(6'd15, 8'h00);
      rd(v); chk("R5 frame flag from live test", v, 8'h80);

      // R6: flag sets in the very cycle of a read
      wr_reg(6'd15, 8'h01);
      wr_reg(6'd19, 8'd60);
      scan_line = 8'd60; hblank = 1'b1; cpu_rd = 1'b1;
      cyc();
      cpu_rd = 1'b0; hblank = 1'b0;
      chk("R6 race read returns 0", cpu_rdata, 8'h00);
      rd(v); chk("R6 race flag kept", v, 8'h01);
      rd(v); chk("R6 race flag then cleared", v, 8'h00);

      // R2: read in the middle of a byte pair drops the pair
      wr_byte(8'h05);
      rd(v);
      wr_byte(8'h07);
      wr_byte(8'h93);
      hpulse(8'd7);
      rd(v); chk("R2 sequencer restarted", v, 8'h01);

      // R1: second byte without bit 7 writes nothing
      wr_byte(8'h09);
      wr_byte(8'h13);
      hpulse(8'd9);
      rd(v); chk("R1 no write without bit 7", v, 8'h00);
      hpulse(8'd7);
      rd(v); chk("R1 line register kept", v, 8'h01);

      // R3: selector 3 returns zero and clears nothing
      hpulse(8'd7);
      wr_reg(6'd15, 8'h03);
      rd(v); chk("R3 selector 3 reads zero", v, 8'h00);
      wr_reg(6'd15, 8'h01);
      rd(v); chk("R3 flag kept across other read", v, 8'h01);

      // R9: reset mid-run
      hpulse(8'd7);
      rst_n = 1'b0;
      cyc();
      rst_n = 1'b1;
      chk("R9 rdata on reset", cpu_rdata, 8'h00);
      rd(v); chk("R9 status 0 selected", v, 8'h00);
      wr_reg(6'd15, 8'h01);
      rd(v); chk("R9 line flag cleared", v, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule